// File: doc/BRIEF.md
# Pulse Timing Measurement Unit

This block turns a frequency-coded or pulse-width-coded digital waveform into a 16-bit number. Typical sources are a voltage-to-frequency converter or a one-shot whose pulse width follows an analog level. The waveform arrives asynchronously. The block synchronizes it and detects its edges. It then applies one of three measurements selected at start:

- the length of the high or low part of one cycle;
- the length of one whole cycle;
- the number of rising edges seen inside a gate window of fixed length.

Timing modes are single-shot. Each measurement waits for the first qualifying edge after start, so a partial cycle never enters the result. Conversion time in these modes therefore follows the input. The edge-count mode repeats windows back to back, so its conversion time is constant: 2^GATE_LOG2 clocks, with a default of 2^23, which is 0.8388608 s at 10 MHz. All counters saturate rather than wrap.

Top module: `pulse_meter`

## Requirements
- R1: After reset, `valid`, `overflow` and `result` are all 0.
- R2: `sig_in` passes through a two-flop synchronizer, and edges are found by a registered compare of consecutive synchronized samples. Every interval is counted in clocks between two such edges, so a level held for N clocks measures N.
- R3: Mode code 0 with `pol`=1 measures the high part of one input cycle, from rising edge to falling edge.
- R4: Mode code 0 with `pol`=0 measures the low part of one input cycle, from falling edge to rising edge.
- R5: Mode code 1 measures one whole cycle. It runs from a rising edge to the next rising edge when `pol`=1, and from a falling edge to the next falling edge when `pol`=0.
- R6: In modes 0 and 1, timing begins only at the first qualifying edge after `start`. A level already present at `start` is never measured.
- R7: A count that would pass 0xFFFF stays at 0xFFFF. That result is posted with `overflow`=1.
- R8: Mode code 2 counts rising edges in consecutive windows of exactly 2^GATE_LOG2 clocks. It posts one result per window, and each new window begins on the clock after the previous one closes.
- R9: `valid` is high for exactly one clock per result. `result` and `overflow` hold between results. After modes 0 and 1 post their result, no further result appears until the next `start`.
- R10: A `start` in any state aborts the running measurement and begins a new one with the newly sampled mode and polarity. Mode code 3 with `start` stops all measurement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| sig_in | input | 1 | Asynchronous waveform to be measured |
| mode | input | 2 | 0 on-time, 1 period, 2 edge count, 3 stop; sampled with `start` |
| pol | input | 1 | 1 selects high part / rising edges, 0 selects low part / falling edges |
| start | input | 1 | One-clock pulse that begins (or aborts and restarts) a measurement |
| result | output | 16 | Last measured value |
| valid | output | 1 | One-clock pulse when a new `result` is posted |
| overflow | output | 1 | Set with a result whose count saturated |

## Verification
The embedded assertions check several properties on every clock:
- the synchronized edge stream never shows a rise and a fall together, or two rises in a row;
- a timing run is entered only from a qualifying edge;
- a saturated count stays saturated;
- completion pulses last one clock and never come from both engines at once;
- an overflowed result reads 0xFFFF;
- a gate window never reports more rising edges than it can hold.

Only the bench scenarios can show the rest:
- that measured values equal the programmed high, low and cycle lengths for both polarities;
- that a partial first level is skipped;
- that timing modes stay single-shot;
- that a restart discards the run in progress;
- that gate windows deliver the right edge count back to back and go quiet after a stop.

// File: rtl/ptm_pkg.sv
package ptm_pkg;

    localparam int unsigned RES_W = 16;

    typedef enum logic [1:0] {
        MODE_ONTIME = 2'd0,
        MODE_PERIOD = 2'd1,
        MODE_COUNT  = 2'd2,
        MODE_STOP   = 2'd3
    } ptm_mode_e;

    typedef enum logic [1:0] {
        IV_IDLE = 2'd0,
        IV_WAIT = 2'd1,
        IV_RUN  = 2'd2
    } ptm_iv_state_e;

    typedef struct packed {
        logic             ovf;
        logic [RES_W-1:0] value;
    } ptm_result_t;

    typedef struct packed {
        logic rise;
        logic fall;
    } ptm_edges_t;

    // Saturating increment: once full, value stays and ovf is raised.
    function automatic ptm_result_t sat_inc(input ptm_result_t r);
        ptm_result_t n;
        n = r;
        if (&r.value) begin
            n.ovf = 1'b1;
        end else begin
            n.value = r.value + RES_W'(1);
        end
        return n;
    endfunction

endpackage

// File: rtl/ptm_edge_sync.sv
module ptm_edge_sync
    import ptm_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sig_in,
    output ptm_edges_t edges
);

    localparam int unsigned TOP = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            prev_q <= 1'b0;
            edges  <= '0;
        end else begin
            sync_q     <= {sync_q[TOP-1:0], sig_in};
            prev_q     <= sync_q[TOP];
            edges.rise <= sync_q[TOP] & ~prev_q;
            edges.fall <= ~sync_q[TOP] & prev_q;
        end
    end

    // R2: a registered edge stream can never report both directions at once
    a_r2_edges_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(edges.rise && edges.fall));

    // R2: two consecutive rises are impossible without a fall between
    a_r2_no_double_rise: assert property (@(posedge clk) disable iff (rst)
        edges.rise |=> !edges.rise);

endmodule

// File: rtl/ptm_interval.sv
module ptm_interval
    import ptm_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        arm,
    input  logic        abort,
    input  logic        pol,
    input  logic        whole_cycle,
    input  ptm_edges_t  edges,
    output logic        done,
    output ptm_result_t res
);

    ptm_iv_state_e state;
    ptm_result_t   cnt;
    logic          pol_q;
    logic          whole_q;
    logic          start_edge;
    logic          end_edge;

    always_comb begin
        start_edge = pol_q ? edges.rise : edges.fall;
        if (whole_q) begin
            end_edge = start_edge;
        end else begin
            end_edge = pol_q ? edges.fall : edges.rise;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= IV_IDLE;
            cnt     <= '0;
            pol_q   <= 1'b0;
            whole_q <= 1'b0;
            done    <= 1'b0;
            res     <= '0;
        end else begin
            done <= 1'b0;
            if (arm) begin
                state   <= IV_WAIT;
                pol_q   <= pol;
                whole_q <= whole_cycle;
            end else if (abort) begin
                state <= IV_IDLE;
            end else begin
                case (state)
                    IV_WAIT: begin
                        if (start_edge) begin
                            cnt   <= '{ovf: 1'b0, value: RES_W'(1)};
                            state <= IV_RUN;
                        end
                    end
                    IV_RUN: begin
                        if (end_edge) begin
                            res   <= cnt;
                            done  <= 1'b1;
                            state <= IV_IDLE;
                        end else begin
                            cnt <= sat_inc(cnt);
                        end
                    end
                    default: state <= IV_IDLE;
                endcase
            end
        end
    end

    // R9: completion is a single-cycle pulse
    a_r9_done_one_cycle: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R6: a timing run is entered only on a qualifying edge seen while waiting
    a_r6_run_from_edge: assert property (@(posedge clk) disable iff (rst)
        (state == IV_RUN && $past(state) == IV_WAIT) |-> $past(start_edge));

    // R7: a saturated count stays saturated while the run continues
    a_r7_sat_sticky: assert property (@(posedge clk) disable iff (rst)
        (state == IV_RUN && cnt.ovf && !end_edge && !arm && !abort)
        |=> (cnt.ovf && (&cnt.value)));

endmodule

// File: rtl/ptm_gate_count.sv
module ptm_gate_count
    import ptm_pkg::*;
#(
    parameter int unsigned GATE_LOG2 = 23
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        arm,
    input  logic        abort,
    input  logic        rise,
    output logic        done,
    output ptm_result_t res
);

    localparam longint unsigned MAX_EDGES = 64'd1 << (GATE_LOG2 - 1);

    logic [GATE_LOG2-1:0] gate_q;
    logic                 active_q;
    ptm_result_t          acc;
    ptm_result_t          acc_next;

    always_comb begin
        acc_next = rise ? sat_inc(acc) : acc;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gate_q   <= '0;
            active_q <= 1'b0;
            acc      <= '0;
            done     <= 1'b0;
            res      <= '0;
        end else begin
            done <= 1'b0;
            if (arm) begin
                active_q <= 1'b1;
                gate_q   <= '0;
                acc      <= '0;
            end else if (abort) begin
                active_q <= 1'b0;
            end else if (active_q) begin
                gate_q <= gate_q + 1'b1;
                if (&gate_q) begin
                    res  <= acc_next;
                    done <= 1'b1;
                    acc  <= '0;
                end else begin
                    acc <= acc_next;
                end
            end
        end
    end

    // R8: windows are longer than one clock, so completions never touch
    a_r8_done_spacing: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8: a window cannot hold more rising edges than half its length
    a_r8_count_bound: assert property (@(posedge clk) disable iff (rst)
        done |-> (64'(res.value) <= MAX_EDGES));

endmodule

// File: rtl/pulse_meter.sv
module pulse_meter
    import ptm_pkg::*;
#(
    parameter int unsigned GATE_LOG2   = 23,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        sig_in,
    input  logic [1:0]  mode,
    input  logic        pol,
    input  logic        start,
    output logic [15:0] result,
    output logic        valid,
    output logic        overflow
);

    ptm_mode_e   mode_sel;
    ptm_edges_t  edges;
    logic        iv_arm;
    logic        iv_abort;
    logic        gc_arm;
    logic        gc_abort;
    logic        iv_done;
    logic        gc_done;
    ptm_result_t iv_res;
    ptm_result_t gc_res;
    ptm_result_t out_q;

    always_comb begin
        mode_sel = ptm_mode_e'(mode);
        iv_arm   = start && (mode_sel == MODE_ONTIME || mode_sel == MODE_PERIOD);
        iv_abort = start && !iv_arm;
        gc_arm   = start && (mode_sel == MODE_COUNT);
        gc_abort = start && !gc_arm;
    end

    ptm_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .sig_in (sig_in),
        .edges  (edges)
    );

    ptm_interval u_interval (
        .clk         (clk),
        .rst         (rst),
        .arm         (iv_arm),
        .abort       (iv_abort),
        .pol         (pol),
        .whole_cycle (mode_sel == MODE_PERIOD),
        .edges       (edges),
        .done        (iv_done),
        .res         (iv_res)
    );

    ptm_gate_count #(.GATE_LOG2(GATE_LOG2)) u_gate (
        .clk   (clk),
        .rst   (rst),
        .arm   (gc_arm),
        .abort (gc_abort),
        .rise  (edges.rise),
        .done  (gc_done),
        .res   (gc_res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
            valid <= 1'b0;
        end else begin
            valid <= iv_done || gc_done;
            if (iv_done) begin
                out_q <= iv_res;
            end else if (gc_done) begin
                out_q <= gc_res;
            end
        end
    end

    assign result   = out_q.value;
    assign overflow = out_q.ovf;

    // R9: only one engine is ever active, so completions never coincide
    a_r9_one_source: assert property (@(posedge clk) disable iff (rst)
        !(iv_done && gc_done));

    // R7: an overflowed result always reads full scale
    a_r7_ovf_full_scale: assert property (@(posedge clk) disable iff (rst)
        (valid && overflow) |-> (&result));

    // R9: the valid strobe lasts one clock
    a_r9_valid_pulse: assert property (@(posedge clk) disable iff (rst)
        valid |=> !valid);

endmodule

// File: tb/pulse_meter_bench.sv
module pulse_meter_bench;

    localparam int CLK_PERIOD = 10;
    localparam int GATE_LOG2  = 8;
    localparam int WINDOW     = 1 << GATE_LOG2;
    localparam int WATCHDOG   = 190000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sig_in = 1'b0;
    logic [1:0]  mode = 2'd0;
    logic        pol = 1'b1;
    logic        start = 1'b0;
    logic [15:0] result;
    logic        valid;
    logic        overflow;

    int compared   = 0;
    int mismatched = 0;
    int unexpected = 0;
    bit finished   = 1'b0;

    logic [16:0] exp_q[$];
    string       tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    pulse_meter #(.GATE_LOG2(GATE_LOG2)) u_pulse_meter (
        .clk      (clk),
        .rst      (rst),
        .sig_in   (sig_in),
        .mode     (mode),
        .pol      (pol),
        .start    (start),
        .result   (result),
        .valid    (valid),
        .overflow (overflow)
    );

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    task automatic expect_item(input bit ovf, input int val, input string tag);
        exp_q.push_back({ovf, 16'(val)});
        tag_q.push_back(tag);
    endtask

    task automatic hold(input logic lvl, input int n);
        @(negedge clk);
        sig_in = lvl;
        repeat (n - 1) @(negedge clk);
    endtask

    task automatic pulse_start(input logic [1:0] m, input logic p);
        @(negedge clk);
        mode  = m;
        pol   = p;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic square(input int half, input int cycles);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            sig_in = ((i / half) % 2) == 1;
        end
    endtask

    task automatic drain(input int limit);
        for (int i = 0; i < limit; i++) begin
            if (exp_q.size() == 0) break;
            @(negedge clk);
        end
        check(exp_q.size() == 0, "drain: pending expected results", exp_q.size(), 0);
    endtask

    // Monitor: compares every posted result against the scoreboard queue.
    always @(negedge clk) begin
        if (!rst && valid) begin
            if (exp_q.size() == 0) begin
                unexpected++;
                compared++;
                mismatched++;
                $display("FAIL R9: unexpected result actual %0d expected none", result);
            end else begin
                logic [16:0] e;
                string       t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check({overflow, result} == e, t, int'({overflow, result}), int'(e));
            end
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            mismatched++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        int snap;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(valid == 1'b0, "R1 valid after reset", valid, 0);
        check(result == 16'd0, "R1 result after reset", result, 0);
        check(overflow == 1'b0, "R1 overflow after reset", overflow, 0);

        // R3 and R2: high part of 37 clocks
        hold(0, 5);
        expect_item(0, 37, "R3 on-time high 37");
        pulse_start(2'd0, 1'b1);
        hold(0, 5); hold(1, 37); hold(0, 20);
        // R9: later cycles must not produce another result
        hold(1, 10); hold(0, 10);
        drain(50);

        // R6: signal already high at start, partial level skipped
        hold(1, 5);
        expect_item(0, 21, "R6 partial first level skipped");
        pulse_start(2'd0, 1'b1);
        hold(1, 10); hold(0, 6); hold(1, 21); hold(0, 10);
        drain(50);

        // R4: low part of 44 clocks
        hold(1, 5);
        expect_item(0, 44, "R4 on-time low 44");
        pulse_start(2'd0, 1'b0);
        hold(1, 5); hold(0, 44); hold(1, 10);
        drain(50);

        // R5: period rising to rising, 13 + 19
        hold(0, 5);
        expect_item(0, 32, "R5 period rising 32");
        pulse_start(2'd1, 1'b1);
        hold(0, 4); hold(1, 13); hold(0, 19); hold(1, 5); hold(0, 5);
        hold(1, 7); hold(0, 7);
        drain(50);

        // R5: period falling to falling, 25 + 9
        expect_item(0, 34, "R5 period falling 34");
        pulse_start(2'd1, 1'b0);
        hold(0, 3); hold(1, 6); hold(0, 25); hold(1, 9); hold(0, 4);
        drain(50);

        // R10: restart in the middle of an on-time run with period mode
        pulse_start(2'd0, 1'b1);
        hold(0, 3); hold(1, 10);
        expect_item(0, 17, "R10 restart to period 17");
        pulse_start(2'd1, 1'b1);
        hold(1, 5); hold(0, 7); hold(1, 8); hold(0, 9); hold(1, 3); hold(0, 5);
        drain(50);

        // R7: saturation on a very long high level
        hold(0, 5);
        expect_item(1, 16'hFFFF, "R7 saturated on-time");
        pulse_start(2'd0, 1'b1);
        hold(0, 3); hold(1, 70000); hold(0, 10);
        drain(50);

        // R8: back-to-back gate windows, period 16 gives 16 rises per window
        fork
            square(8, 3 * WINDOW + 150);
            begin
                repeat (40) @(negedge clk);
                expect_item(0, WINDOW / 16, "R8 window 1 of 3");
                expect_item(0, WINDOW / 16, "R8 window 2 of 3");
                expect_item(0, WINDOW / 16, "R8 window 3 of 3");
                pulse_start(2'd2, 1'b1);
            end
        join
        pulse_start(2'd3, 1'b0);
        drain(20);

        // R8: slower input, period 32 gives 8 rises per window
        fork
            square(16, 2 * WINDOW + 150);
            begin
                repeat (40) @(negedge clk);
                expect_item(0, WINDOW / 32, "R8 slow window 1");
                expect_item(0, WINDOW / 32, "R8 slow window 2");
                pulse_start(2'd2, 1'b0);
            end
        join
        pulse_start(2'd3, 1'b0);
        drain(20);

        // R8: constant input gives zero
        expect_item(0, 0, "R8 constant input zero");
        pulse_start(2'd2, 1'b1);
        hold(0, WINDOW + 40);
        pulse_start(2'd3, 1'b0);
        drain(20);

        // R10: after a stop, toggling input produces no result
        snap = unexpected;
        square(4, 3 * WINDOW);
        check(unexpected == snap, "R10 silent after stop", unexpected - snap, 0);
        check(valid == 1'b0, "R9 valid low when idle", valid, 0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule